// File: doc/BRIEF.md
# Iterative Step Square Root Unit

This block computes the unsigned integer square root of a 32-bit argument. The argument arrives as an upper and a lower 16-bit word. It uses the conditional-subtract-and-shift datapath that a step divider uses. Each step moves one pair of argument bits from the top of the argument register into a partial remainder. The step then subtracts a trial value made from twice the partial root with a trial bit set below it. When the subtraction does not borrow, the step keeps the difference and the new root bit is a one.

A one-hot trial-bit register walks right from the MSB of the 16-bit root, so it produces exactly 16 root bits. An idle unit accepts a start strobe and stays busy for a fixed 25 cycles. The first 16 of those cycles are steps; the rest are padding, so software sees the same latency for every argument. After the last busy cycle the unit pulses done. The root output then holds the root and the remainder output holds the argument minus the root squared. Both values hold until the next accepted start.

Top module: `step_sqrt`

## Requirements
- R1: After reset, busy_o, done_o, root_o and rem_o are all zero.
- R2: A start_i high at a clock edge while busy_o is low is accepted. busy_o is then high for exactly 25 consecutive cycles, starting at that edge.
- R3: done_o is high for exactly one cycle, the cycle right after busy_o falls, and is never high together with busy_o.
- R4: With X = {arg_hi_i, arg_lo_i} taken at the accepting edge, root_o when done_o is high satisfies root_o² ≤ X < (root_o+1)².
- R5: When done_o is high, rem_o equals X − root_o², which never exceeds 2·root_o.
- R6: A start_i high while busy_o is high is ignored. It does not change the latency or the result of the operation in progress, and it does not change the argument that operation uses.
- R7: From done_o onward, root_o and rem_o hold their values until the next accepted start.
- R8: X = 0 gives root 0 and remainder 0. X = 0xFFFFFFFF gives root 65535 and remainder 131070. A perfect square gives remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| arg_hi_i | input | 16 | Upper word of the argument |
| arg_lo_i | input | 16 | Lower word of the argument |
| busy_o | output | 1 | High while an operation runs |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| root_o | output | 16 | Integer square root |
| rem_o | output | 18 | Remainder, argument minus root squared |

## Verification
The bench sweeps every argument from 0 to 1500. It also runs the squares and square-minus-one values at every power-of-two root, plus a pseudo-random set, and checks each root against an arithmetic bound. A design that gets the bit-pair alignment wrong, or that truncates the partial remainder, gives roots that are off by one near perfect squares or wrong at the all-ones argument. The bench counts busy cycles and looks for a lone done pulse, which catches an off-by-one latency. It also fires a second start with a different argument in mid-operation, which exposes a unit that restarts or reloads its argument. A final wait with start low shows whether the results drift after done.

// File: rtl/step_sqrt_pkg.sv
package step_sqrt_pkg;
  localparam int unsigned ROOT_W_DEF  = 16;
  localparam int unsigned LATENCY_DEF = 25;
endpackage

// File: rtl/step_sqrt_stage.sv
// One restoring step: bring in a bit pair, try subtracting 4p+1.
module step_sqrt_stage #(
  parameter int unsigned ROOT_W = 16,
  localparam int unsigned ACC_W = ROOT_W + 2,
  localparam int unsigned EXT_W = ACC_W + 2
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [1:0]        pair_i,
  input  logic [ROOT_W-1:0] root_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ROOT_W-1:0] root_o
);
  logic [EXT_W-1:0] acc_sh, trial, diff;
  logic             fits;

  always_comb begin
    acc_sh = {acc_i, pair_i};
    trial  = {2'b00, root_i, 2'b01};  // twice the root, trial bit OR'd below
    fits   = acc_sh >= trial;
    diff   = acc_sh - trial;
    acc_o  = ACC_W'(fits ? diff : acc_sh);
    root_o = {root_i[ROOT_W-2:0], fits};
  end
endmodule

// File: rtl/step_sqrt_ctrl.sv
module step_sqrt_ctrl #(
  parameter int unsigned ROOT_W  = 16,
  parameter int unsigned LATENCY = 25,
  localparam int unsigned CNT_W  = $clog2(LATENCY)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ROOT_W-1:0] tbit_q;
  logic              last;

  assign last   = cnt_q == CNT_W'(LATENCY - 1);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o && (tbit_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tbit_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= busy_o && last;
      if (load_o) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
        tbit_q <= {1'b1, {(ROOT_W-1){1'b0}}};
      end else if (busy_o) begin
        tbit_q <= tbit_q >> 1;
        if (last) busy_o <= 1'b0;
        else      cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= CNT_W'(LATENCY - 1));
  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  assert_tbit_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tbit_q));
endmodule

// File: rtl/step_sqrt.sv
module step_sqrt
  import step_sqrt_pkg::*;
#(
  parameter int unsigned ROOT_W  = ROOT_W_DEF,
  parameter int unsigned LATENCY = LATENCY_DEF,
  localparam int unsigned ARG_W  = 2 * ROOT_W,
  localparam int unsigned ACC_W  = ROOT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROOT_W-1:0] arg_hi_i,
  input  logic [ROOT_W-1:0] arg_lo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ROOT_W-1:0] root_o,
  output logic [ACC_W-1:0]  rem_o
);
  logic              load, step;
  logic [ARG_W-1:0]  arg_q;
  logic [ACC_W-1:0]  acc_q, acc_nxt;
  logic [ROOT_W-1:0] root_q, root_nxt;

  step_sqrt_ctrl #(.ROOT_W(ROOT_W), .LATENCY(LATENCY)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .step_o(step), .busy_o, .done_o
  );

  step_sqrt_stage #(.ROOT_W(ROOT_W)) i_stage (
    .acc_i(acc_q), .pair_i(arg_q[ARG_W-1 -: 2]), .root_i(root_q),
    .acc_o(acc_nxt), .root_o(root_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q  <= '0;
      acc_q  <= '0;
      root_q <= '0;
    end else if (load) begin
      arg_q  <= {arg_hi_i, arg_lo_i};
      acc_q  <= '0;
      root_q <= '0;
    end else if (step) begin
      arg_q  <= arg_q << 2;
      acc_q  <= acc_nxt;
      root_q <= root_nxt;
    end
  end

  assign root_o = root_q;
  assign rem_o  = acc_q;

  assert_rem_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({1'b0, rem_o} <= {root_o, 1'b0} + 19'(0)));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(root_o) && $stable(rem_o)));
endmodule

// File: tb/test_step_sqrt.sv
module test_step_sqrt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] hi = '0, lo = '0;
  logic        busy, done;
  logic [15:0] root;
  logic [17:0] rem;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  step_sqrt i_step_sqrt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .arg_hi_i(hi), .arg_lo_i(lo),
    .busy_o(busy), .done_o(done), .root_o(root), .rem_o(rem)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint x);
    longint lo_b = 0, hi_b = 65536;
    while (hi_b - lo_b > 1) begin
      longint mid = (lo_b + hi_b) / 2;
      if (mid * mid <= x) lo_b = mid; else hi_b = mid;
    end
    return lo_b;
  endfunction

  // Run one operation; optional intruding start with other argument mid-run.
  task automatic run(input logic [31:0] x, input bit intrude, input bit timing);
    longint r, e;
    int     nbusy = 0;
    @(negedge clk);
    {hi, lo} = x;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    {hi, lo} = ~x;
    while (busy) begin
      nbusy++;
      if (intrude && nbusy == 5) start = 1'b1;
      if (intrude && nbusy == 7) start = 1'b0;
      @(negedge clk);
      if (nbusy > 40) break;
    end
    start = 1'b0;
    if (timing) begin
      chk("R2 busy length", nbusy, 25);
      chk("R3 done after busy", done, 1);
    end
    r = isqrt(longint'(x));
    e = longint'(x) - r * r;
    chk(intrude ? "R6 root under intruding start" : "R4 root", root, r);
    chk("R5 remainder", rem, e);
    chk("R4 lower bound", (longint'(root) * root <= longint'(x)), 1);
    chk("R4 upper bound", ((longint'(root) + 1) * (longint'(root) + 1) > longint'(x)), 1);
    if (timing) begin
      @(negedge clk);
      chk("R3 done single cycle", done, 0);
      chk("R3 idle after done", busy, 0);
      repeat (3) @(negedge clk);
      chk("R7 root held", root, r);
      chk("R7 rem held", rem, e);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 root", root, 0);
    chk("R1 rem", rem, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'd0, 0, 1);            // R8 zero
    chk("R8 zero root", root, 0);
    run(32'hFFFF_FFFF, 0, 1);    // R8 all ones
    chk("R8 max root", root, 65535);
    chk("R8 max rem", rem, 131070);
    run(32'hFFFE_0001, 0, 1);    // R8 perfect square
    chk("R8 square rem", rem, 0);
    run(32'd1000, 1, 1);         // R6 intruding start
    for (int i = 1; i <= 1500; i++) run(32'(i), 0, 0);
    for (int k = 0; k < 16; k++) begin
      longint s = longint'(1) << k;
      run(32'(s * s), 0, 0);
      run(32'(s * s - 1), 0, 0);
      run(32'((s * 2 - 1) * (s * 2 - 1)), 0, 0);
    end
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      run(seed, (i % 50) == 0, (i % 25) == 0);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule